// File: doc/BRIEF.md
# Disk Boot Sector Fetch Engine

This block loads the first sector of an ATA-style disk (or a CompactFlash card in its true-IDE mode) into a local 512-byte buffer. It needs no processor. It reaches the drive through a plain I/O register bus with a 10-bit port address and 16-bit data. After a start pulse it does five things in order. It writes the task-file registers for a one-sector, 28-bit LBA read. It issues the read command. It polls the status register, first for the busy flag to clear and then for the data-request flag to appear. It pulls 256 data words into the buffer. Finally it checks that the last word carries the boot signature.

If the status poll stays unsuccessful for longer than a programmable number of cycles, the attempt is abandoned and the whole register sequence is sent again. After the last permitted attempt, the block reports a timeout code. A sector that arrives intact but has the wrong signature is reported at once, with no retry. On success the block presents the drive number and the load address that the loaded code expects. A consumer then copies or executes the sector through the byte read port of the buffer.

Top module: `bootsec_fetch`

## Requirements
- R1: Out of reset `busy`, `done` and `error` are 0, `status_code` is 0x00, and `io_wr` and `io_rd` are 0. While idle, a `start` pulse latches `lba`, raises `busy` and clears `done` and `error` on the next edge. A `start` while `busy` is 1 has no effect on the transfer, on the LBA used or on the result.
- R2: Each attempt writes these ports in this order, one write per cycle: 0x1F2 with 0x0001 (one sector), 0x1F3 with LBA bits 7:0, 0x1F4 with bits 15:8, 0x1F5 with bits 23:16, and 0x1F6 with 0xE0 OR LBA bits 27:24 (LBA mode, master drive). The last write puts the read command 0x20 on port 0x1F7.
- R3: After the command the block reads port 0x1F7 once per cycle. It first waits for bit 7 (busy) to be 0 and then for bit 3 (data request) to be 1. It reads port 0x1F0 only after that.
- R4: The block reads 256 consecutive words from port 0x1F0. It stores word i little-endian: bits 7:0 at buffer byte 2i and bits 15:8 at byte 2i+1.
- R5: An attempt fails on the `timeout_limit`-th status read since its command that does not advance the poll (busy still 1, or data request still 0). A limit of 0 behaves as 1. If busy clears on the first read of an attempt, the attempt therefore spans 7 + limit cycles. If busy never clears, it spans 6 + limit cycles.
- R6: A failed attempt is repeated with the full register sequence, up to 3 attempts in total. When the third attempt fails, `done` and `error` rise together with `status_code` 0xBB.
- R7: Once all 256 words are stored, a last word (bytes 510 and 511) other than 0xAA55 gives `done`, `error` and `status_code` 0xBC, with no retry.
- R8: On success `done` is 1, `error` is 0, `status_code` is 0x00, `boot_drive` is 0x80 and `load_addr` is 0x7C00. In every other case `boot_drive` and `load_addr` read 0.
- R9: `buf_rdata` shows the buffer byte addressed by `buf_raddr` one clock edge after the address is sampled.
- R10: `done`, `error` and `status_code` hold their values until the next accepted `start`.
- R11: `io_wr` and `io_rd` are never 1 together. Writes target only ports 0x1F2 to 0x1F7. Reads target only 0x1F0 and 0x1F7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load when idle |
| lba | input | 28 | Sector address to read |
| timeout_limit | input | TMO_W | Unsuccessful status reads allowed per attempt |
| io_addr | output | 10 | I/O port address |
| io_wr | output | 1 | Write strobe, one cycle per write |
| io_rd | output | 1 | Read strobe, data sampled in the same cycle |
| io_wdata | output | 16 | Write data |
| io_rdata | input | 16 | Read data returned by the drive |
| buf_raddr | input | 9 | Buffer byte address |
| buf_rdata | output | 8 | Buffer byte, one edge after the address |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished (held) |
| error | output | 1 | Load finished with a failure (held) |
| status_code | output | 8 | 0x00 ok, 0xBB timeout, 0xBC bad signature |
| boot_drive | output | 8 | 0x80 on success, else 0 |
| load_addr | output | 16 | 0x7C00 on success, else 0 |

## Verification
Call the clock edge that samples `start` edge 0. The timeout result is due exactly 3 × (6 + P) edges after edge 0, where P is the number of poll cycles in one attempt (limit + 1 when busy is already clear, limit when busy never clears). The bench samples `done` at the falling edge before that edge, where it must be low, and at the falling edge after it, where it must be high. Success results depend on how long the drive stays busy, so the bench waits for `done` under a bound and then checks the drive register values it captured when the command was written. Buffer bytes are read by placing an address at a falling edge and comparing `buf_rdata` at the next falling edge, one register later.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    localparam logic [9:0] PORT_DATA = 10'h1F0;
    localparam logic [9:0] PORT_SCNT = 10'h1F2;
    localparam logic [9:0] PORT_LBA0 = 10'h1F3;
    localparam logic [9:0] PORT_LBA1 = 10'h1F4;
    localparam logic [9:0] PORT_LBA2 = 10'h1F5;
    localparam logic [9:0] PORT_DRV  = 10'h1F6;
    localparam logic [9:0] PORT_CMD  = 10'h1F7;

    localparam logic [7:0]  CMD_READ    = 8'h20;
    localparam logic [7:0]  CODE_OK     = 8'h00;
    localparam logic [7:0]  CODE_TMO    = 8'hBB;
    localparam logic [7:0]  CODE_BADSIG = 8'hBC;
    localparam logic [7:0]  BOOT_DRIVE  = 8'h80;
    localparam logic [15:0] LOAD_ADDR   = 16'h7C00;
    localparam logic [15:0] BOOT_SIG    = 16'hAA55;

    localparam int STS_BSY = 7;
    localparam int STS_DRQ = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCNT,
        ST_LBA0,
        ST_LBA1,
        ST_LBA2,
        ST_DRV,
        ST_CMD,
        ST_WAIT_BSY,
        ST_WAIT_DRQ,
        ST_DATA
    } seq_state_e;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [9:0]  addr;
        logic [15:0] wdata;
    } io_req_t;

    typedef struct packed {
        logic       done;
        logic       error;
        logic [7:0] code;
    } result_t;

    function automatic logic [7:0] drive_byte(input logic [3:0] lba_top);
        return 8'hE0 | {4'h0, lba_top};
    endfunction

endpackage

// File: rtl/bsl_poll_timer.sv
module bsl_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             miss,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   next_cnt;

    assign next_cnt = (TMO_W+1)'(cnt_q) + 1'b1;
    assign expired  = miss && (next_cnt >= (TMO_W+1)'(limit));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (miss && !expired) begin
            cnt_q <= next_cnt[TMO_W-1:0];
        end
    end
endmodule

// File: rtl/bsl_sector_buf.sv
module bsl_sector_buf #(
    parameter int WORDS = 256,
    localparam int WA_W = $clog2(WORDS),
    localparam int BA_W = WA_W + 1
) (
    input  logic            clk,
    input  logic            we,
    input  logic [WA_W-1:0] waddr,
    input  logic [15:0]     wdata,
    input  logic [BA_W-1:0] raddr,
    output logic [7:0]      rdata
);
    logic sel_q;

    for (genvar b = 0; b < 2; b++) begin : gen_bank
        logic [7:0] mem [WORDS];
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (we) begin
                mem[waddr] <= wdata[b*8 +: 8];
            end
            q <= mem[raddr[BA_W-1:1]];
        end
    end

    always_ff @(posedge clk) begin
        sel_q <= raddr[0];
    end

    assign rdata = sel_q ? gen_bank[1].q : gen_bank[0].q;
endmodule

// File: rtl/bsl_seq.sv
module bsl_seq
    import bsl_pkg::*;
#(
    parameter int WORDS   = 256,
    parameter int MAX_TRY = 3,
    localparam int WA_W   = $clog2(WORDS),
    localparam int TRY_W  = $clog2(MAX_TRY + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [27:0]     lba,
    input  logic [15:0]     io_rdata,
    input  logic            tmo_expired,
    output io_req_t         io_req,
    output logic            poll_clear,
    output logic            poll_miss,
    output logic            buf_we,
    output logic [WA_W-1:0] buf_waddr,
    output logic [15:0]     buf_wdata,
    output logic            busy,
    output result_t         res
);
    seq_state_e       st_q;
    logic [27:0]      lba_q;
    logic [TRY_W-1:0] try_q;
    logic [WA_W-1:0]  word_q;
    logic             sts_bsy;
    logic             sts_drq;
    logic             last_try;

    assign sts_bsy  = io_rdata[STS_BSY];
    assign sts_drq  = io_rdata[STS_DRQ];
    assign last_try = (try_q == TRY_W'(MAX_TRY - 1));

    always_comb begin
        io_req = '0;
        unique case (st_q)
            ST_SCNT:     io_req = '{wr: 1'b1, rd: 1'b0, addr: PORT_SCNT, wdata: 16'h0001};
            ST_LBA0:     io_req = '{wr: 1'b1, rd: 1'b0, addr: PORT_LBA0, wdata: {8'h00, lba_q[7:0]}};
            ST_LBA1:     io_req = '{wr: 1'b1, rd: 1'b0, addr: PORT_LBA1, wdata: {8'h00, lba_q[15:8]}};
            ST_LBA2:     io_req = '{wr: 1'b1, rd: 1'b0, addr: PORT_LBA2, wdata: {8'h00, lba_q[23:16]}};
            ST_DRV:      io_req = '{wr: 1'b1, rd: 1'b0, addr: PORT_DRV,
                                    wdata: {8'h00, drive_byte(lba_q[27:24])}};
            ST_CMD:      io_req = '{wr: 1'b1, rd: 1'b0, addr: PORT_CMD, wdata: {8'h00, CMD_READ}};
            ST_WAIT_BSY,
            ST_WAIT_DRQ: io_req = '{wr: 1'b0, rd: 1'b1, addr: PORT_CMD, wdata: 16'h0000};
            ST_DATA:     io_req = '{wr: 1'b0, rd: 1'b1, addr: PORT_DATA, wdata: 16'h0000};
            default:     io_req = '0;
        endcase
    end

    assign poll_clear = (st_q == ST_CMD);
    assign poll_miss  = ((st_q == ST_WAIT_BSY) && sts_bsy) ||
                        ((st_q == ST_WAIT_DRQ) && !sts_drq);
    assign buf_we     = (st_q == ST_DATA);
    assign buf_waddr  = word_q;
    assign buf_wdata  = io_rdata;
    assign busy       = (st_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            lba_q  <= '0;
            try_q  <= '0;
            word_q <= '0;
            res    <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        lba_q <= lba;
                        try_q <= '0;
                        res   <= '0;
                        st_q  <= ST_SCNT;
                    end
                end
                ST_SCNT: st_q <= ST_LBA0;
                ST_LBA0: st_q <= ST_LBA1;
                ST_LBA1: st_q <= ST_LBA2;
                ST_LBA2: st_q <= ST_DRV;
                ST_DRV:  st_q <= ST_CMD;
                ST_CMD: begin
                    word_q <= '0;
                    st_q   <= ST_WAIT_BSY;
                end
                ST_WAIT_BSY, ST_WAIT_DRQ: begin
                    if ((st_q == ST_WAIT_BSY) && !sts_bsy) begin
                        st_q <= ST_WAIT_DRQ;
                    end else if ((st_q == ST_WAIT_DRQ) && sts_drq) begin
                        st_q <= ST_DATA;
                    end else if (tmo_expired) begin
                        if (last_try) begin
                            res  <= '{done: 1'b1, error: 1'b1, code: CODE_TMO};
                            st_q <= ST_IDLE;
                        end else begin
                            try_q <= try_q + 1'b1;
                            st_q  <= ST_SCNT;
                        end
                    end
                end
                ST_DATA: begin
                    word_q <= word_q + 1'b1;
                    if (word_q == WA_W'(WORDS - 1)) begin
                        st_q <= ST_IDLE;
                        if (io_rdata == BOOT_SIG) begin
                            res <= '{done: 1'b1, error: 1'b0, code: CODE_OK};
                        end else begin
                            res <= '{done: 1'b1, error: 1'b1, code: CODE_BADSIG};
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bootsec_fetch.sv
module bootsec_fetch
    import bsl_pkg::*;
#(
    parameter int TMO_W        = 16,
    parameter int MAX_TRY      = 3,
    parameter int SECTOR_BYTES = 512,
    localparam int WORDS       = SECTOR_BYTES / 2,
    localparam int WA_W        = $clog2(WORDS),
    localparam int BA_W        = $clog2(SECTOR_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [27:0]      lba,
    input  logic [TMO_W-1:0] timeout_limit,
    output logic [9:0]       io_addr,
    output logic             io_wr,
    output logic             io_rd,
    output logic [15:0]      io_wdata,
    input  logic [15:0]      io_rdata,
    input  logic [BA_W-1:0]  buf_raddr,
    output logic [7:0]       buf_rdata,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [7:0]       status_code,
    output logic [7:0]       boot_drive,
    output logic [15:0]      load_addr
);
    io_req_t         req;
    result_t         res;
    logic            poll_clear;
    logic            poll_miss;
    logic            tmo_expired;
    logic            buf_we;
    logic [WA_W-1:0] buf_waddr;
    logic [15:0]     buf_wdata;
    logic            ok;

    bsl_seq #(.WORDS(WORDS), .MAX_TRY(MAX_TRY)) u_seq (
        .clk(clk), .rst(rst), .start(start), .lba(lba), .io_rdata(io_rdata),
        .tmo_expired(tmo_expired), .io_req(req), .poll_clear(poll_clear),
        .poll_miss(poll_miss), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .busy(busy), .res(res)
    );

    bsl_poll_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst(rst), .clear(poll_clear), .miss(poll_miss),
        .limit(timeout_limit), .expired(tmo_expired)
    );

    bsl_sector_buf #(.WORDS(WORDS)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr(buf_raddr), .rdata(buf_rdata)
    );

    assign io_addr     = req.addr;
    assign io_wr       = req.wr;
    assign io_rd       = req.rd;
    assign io_wdata    = req.wdata;
    assign done        = res.done;
    assign error       = res.error;
    assign status_code = res.code;
    assign ok          = res.done && !res.error;
    assign boot_drive  = ok ? BOOT_DRIVE : 8'h00;
    assign load_addr   = ok ? LOAD_ADDR : 16'h0000;
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [9:0]  io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [15:0] io_wdata,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic [7:0]  status_code,
    input logic [7:0]  boot_drive,
    input logic [15:0] load_addr
);
    assert_rw_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_rd));

    assert_wr_port_R11: assert property (@(posedge clk) disable iff (rst)
        io_wr |-> (io_addr >= 10'h1F2 && io_addr <= 10'h1F7));

    assert_rd_port_R11: assert property (@(posedge clk) disable iff (rst)
        io_rd |-> (io_addr == 10'h1F0 || io_addr == 10'h1F7));

    assert_cmd_after_drv_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == 10'h1F7) |->
            (io_wdata == 16'h0020 && $past(io_wr && io_addr == 10'h1F6)));

    assert_drv_lba_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == 10'h1F6) |-> io_wdata[7:4] == 4'hE);

    assert_data_after_poll_R3: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == 10'h1F0 && !$past(io_rd && io_addr == 10'h1F0)) |->
            $past(io_rd && io_addr == 10'h1F7));

    assert_ok_report_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> (status_code == 8'h00 && boot_drive == 8'h80 &&
                              load_addr == 16'h7C00));

    assert_err_report_R8: assert property (@(posedge clk) disable iff (rst)
        error |-> (boot_drive == 8'h00 && load_addr == 16'h0000 &&
                   (status_code == 8'hBB || status_code == 8'hBC)));

    assert_busy_not_done_R1: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(status_code) && $stable(error)));
endmodule

bind bootsec_fetch bsl_checker u_chk (.*);

// File: tb/sim_bootsec_fetch.sv
module sim_bootsec_fetch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [27:0] lba = '0;
    logic [15:0] tmo = 16'd10;
    logic [9:0]  io_addr;
    logic        io_wr, io_rd;
    logic [15:0] io_wdata;
    logic [15:0] io_rdata;
    logic [8:0]  buf_raddr = '0;
    logic [7:0]  buf_rdata;
    logic        busy, done, error;
    logic [7:0]  status_code, boot_drive;
    logic [15:0] load_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 0;

    always #10 clk = ~clk;

    bootsec_fetch u0 (
        .clk(clk), .rst(rst), .start(start), .lba(lba), .timeout_limit(tmo),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .busy(busy), .done(done), .error(error), .status_code(status_code),
        .boot_drive(boot_drive), .load_addr(load_addr)
    );

    // ---------------- drive model ----------------
    int  cfg_bsy = 0;
    int  cfg_fail_until = 0;
    bit  cfg_badsig = 0;

    logic [7:0] r_scnt, r_l0, r_l1, r_l2, r_drv;
    logic [7:0] s_scnt, s_l0, s_l1, s_l2, s_drv, s_cmd;
    logic [4:0] wmask;
    int  seq_step;
    bit  order_ok;
    int  cmd_count;
    int  bsy_left;
    bit  active, fail_this;
    int  rd_ptr;
    logic m_bsy, m_drq;

    function automatic logic [15:0] sect_word(input int i, input logic [7:0] l0, input bit bad);
        if (i == 255) return bad ? 16'h55AA : 16'hAA55;
        return {l0 ^ 8'(i), ~8'(i)};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            wmask <= '0; cmd_count <= 0; active <= 0; bsy_left <= 0; rd_ptr <= 0;
            fail_this <= 0; order_ok <= 1; seq_step <= 0;
        end else begin
            if (io_wr) begin
                case (io_addr)
                    10'h1F2: begin r_scnt <= io_wdata[7:0]; wmask[0] <= 1; if (seq_step != 0) order_ok <= 0; seq_step <= 1; end
                    10'h1F3: begin r_l0 <= io_wdata[7:0]; wmask[1] <= 1; if (seq_step != 1) order_ok <= 0; seq_step <= 2; end
                    10'h1F4: begin r_l1 <= io_wdata[7:0]; wmask[2] <= 1; if (seq_step != 2) order_ok <= 0; seq_step <= 3; end
                    10'h1F5: begin r_l2 <= io_wdata[7:0]; wmask[3] <= 1; if (seq_step != 3) order_ok <= 0; seq_step <= 4; end
                    10'h1F6: begin r_drv <= io_wdata[7:0]; wmask[4] <= 1; if (seq_step != 4) order_ok <= 0; seq_step <= 5; end
                    10'h1F7: begin
                        if (seq_step != 5 || wmask != 5'h1F) order_ok <= 0;
                        seq_step <= 0; wmask <= '0;
                        s_scnt <= r_scnt; s_l0 <= r_l0; s_l1 <= r_l1; s_l2 <= r_l2;
                        s_drv <= r_drv; s_cmd <= io_wdata[7:0];
                        cmd_count <= cmd_count + 1;
                        fail_this <= (cmd_count < cfg_fail_until);
                        bsy_left <= cfg_bsy; active <= 1; rd_ptr <= 0;
                    end
                    default: order_ok <= 0;
                endcase
            end else if (active && bsy_left > 0) begin
                bsy_left <= bsy_left - 1;
            end
            if (io_rd && io_addr == 10'h1F0) rd_ptr <= rd_ptr + 1;
        end
    end

    assign m_bsy = active && (bsy_left > 0);
    assign m_drq = active && (bsy_left == 0) && !fail_this && (rd_ptr < 256);
    always_comb begin
        if (io_addr == 10'h1F7)      io_rdata = {8'h00, m_bsy, 3'b000, m_drq, 3'b000};
        else if (io_addr == 10'h1F0) io_rdata = sect_word(rd_ptr, s_l0, cfg_badsig);
        else                         io_rdata = 16'h0000;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic kick(input logic [27:0] a, input logic [15:0] lim);
        @(negedge clk);
        lba = a; tmo = lim; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k;
        for (k = 0; k < 4000 && !done; k++) @(negedge clk);
        chk({tag, " done reached"}, done, 1);
    endtask

    task automatic chk_byte(input int a, input logic [7:0] l0, input bit bad);
        logic [15:0] w;
        @(negedge clk);
        buf_raddr = 9'(a);
        @(posedge clk);
        @(negedge clk);
        w = sect_word(a / 2, l0, bad);
        chk($sformatf("R4 R9 buffer byte %0d", a), buf_rdata, (a % 2) ? w[15:8] : w[7:0]);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset error", error, 0);
        chk("R1 reset code", status_code, 8'h00);
        chk("R1 reset io strobes", {io_wr, io_rd}, 2'b00);
    endtask

    task automatic t_good_basic();
        int c0 = cmd_count;
        cfg_bsy = 2; cfg_fail_until = 0; cfg_badsig = 0;
        kick(28'h0000000, 16'd20);
        chk("R1 busy after start", busy, 1);
        wait_done("R8 basic");
        chk("R8 error", error, 0);
        chk("R8 code", status_code, 8'h00);
        chk("R8 boot drive", boot_drive, 8'h80);
        chk("R8 load addr", load_addr, 16'h7C00);
        chk("R6 single command", cmd_count - c0, 1);
        chk("R2 sector count", s_scnt, 8'h01);
        chk("R2 drive byte", s_drv, 8'hE0);
        chk("R2 command code", s_cmd, 8'h20);
        chk("R2 write order", order_ok, 1);
        chk_byte(0, 8'h00, 0);
        chk_byte(1, 8'h00, 0);
        chk_byte(257, 8'h00, 0);
        chk_byte(510, 8'h00, 0);
        chk_byte(511, 8'h00, 0);
    endtask

    task automatic t_high_lba();
        cfg_bsy = 5; cfg_fail_until = 0; cfg_badsig = 0;
        kick(28'hA5C3E71, 16'd20);
        wait_done("R2 high lba");
        chk("R2 lba low", s_l0, 8'h71);
        chk("R2 lba mid", s_l1, 8'h3E);
        chk("R2 lba high", s_l2, 8'h5C);
        chk("R2 drive+lba top", s_drv, 8'hEA);
        chk("R8 code high lba", status_code, 8'h00);
        chk_byte(6, 8'h71, 0);
        chk_byte(7, 8'h71, 0);
    endtask

    task automatic t_timeout_exact(input int bsy, input int lim, input int poll_cycles);
        int c0 = cmd_count;
        int n = 3 * (6 + poll_cycles);
        cfg_bsy = bsy; cfg_fail_until = 32'h7fffffff; cfg_badsig = 0;
        kick(28'h0000123, 16'(lim));
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        chk($sformatf("R5 not done before edge %0d (lim %0d)", n, lim), done, 0);
        @(posedge clk);
        @(negedge clk);
        chk($sformatf("R5 done at edge %0d (lim %0d)", n, lim), done, 1);
        chk("R6 timeout error", error, 1);
        chk("R6 timeout code", status_code, 8'hBB);
        chk("R6 three attempts", cmd_count - c0, 3);
        chk("R8 no drive on error", boot_drive, 8'h00);
        chk("R8 no load addr on error", load_addr, 16'h0000);
    endtask

    task automatic t_retry_recover();
        int c0 = cmd_count;
        cfg_bsy = 1; cfg_fail_until = cmd_count + 2; cfg_badsig = 0;
        kick(28'h0000042, 16'd6);
        wait_done("R6 recover");
        chk("R6 recover error", error, 0);
        chk("R6 recover code", status_code, 8'h00);
        chk("R6 recover attempts", cmd_count - c0, 3);
        chk("R2 order on retries", order_ok, 1);
    endtask

    task automatic t_badsig();
        int c0 = cmd_count;
        cfg_bsy = 0; cfg_fail_until = 0; cfg_badsig = 1;
        kick(28'h0000007, 16'd20);
        wait_done("R7 badsig");
        chk("R7 error", error, 1);
        chk("R7 code", status_code, 8'hBC);
        chk("R7 no retry", cmd_count - c0, 1);
        chk("R8 no drive on badsig", boot_drive, 8'h00);
        cfg_badsig = 0;
    endtask

    task automatic t_busy_ignore();
        int c0 = cmd_count;
        cfg_bsy = 3; cfg_fail_until = 0; cfg_badsig = 0;
        kick(28'h0000033, 16'd20);
        chk("R1 done cleared by start", done, 0);
        chk("R1 error cleared by start", error, 0);
        repeat (30) @(negedge clk);
        start = 1'b1; lba = 28'h00000CC;
        @(negedge clk);
        start = 1'b0;
        wait_done("R1 ignore");
        chk("R1 one command only", cmd_count - c0, 1);
        chk("R1 lba kept", s_l0, 8'h33);
        chk("R1 result ok", status_code, 8'h00);
        chk_byte(4, 8'h33, 0);
    endtask

    task automatic t_hold();
        repeat (12) @(negedge clk);
        chk("R10 done held", done, 1);
        chk("R10 code held", status_code, 8'h00);
        chk("R1 idle after finish", busy, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_good_basic();
        t_high_lba();
        t_timeout_exact(0, 7, 8);
        t_timeout_exact(32'h0fffffff, 4, 4);
        t_timeout_exact(32'h0fffffff, 0, 1);
        t_retry_recover();
        t_badsig();
        t_busy_ignore();
        t_hold();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule